// File: doc/BRIEF.md
# Hardware Trap Controller

This block gathers run-time exception and error conditions from around a processor core and turns them into service requests that no enable bit can suppress. Every trap source owns a sticky bit in a software-visible flag register. Software reads the register and clears bits by writing 0 to them. Separately from the flags, the block keeps a pending set. It offers the core the highest-ranked pending trap as a request together with a vector index. The core uses that index to branch to the dedicated vector-table entry for the trap.

The core pulses an acknowledge when it enters a trap vector and a return strobe when it leaves the handler. A small stack of in-service priorities lets a higher trap nest inside a lower one. On return, the stack puts back the level that was in service before. While any trap service is in progress, a block output stays high. The ordinary interrupt arbiter and the peripheral-event transfer logic use it to hold off their requests. Two pass-through indications show this gating directly: one for the ordinary request level and one for the event-transfer request.

Top module: `trap_ctrl`

## Requirements
- R1: While reset is high, and on the first clock after it, the flag register reads 0, no request is raised, the block output is low and the in-service level reads 0.
- R2: A trap event on bit i sets flag bit i at the next clock edge. No enable, no active service and no other input can prevent this. An event arriving in the same cycle as a clearing write leaves the bit set.
- R3: Flag bits are sticky. A software write clears exactly the bits written as 0 and keeps the bits written as 1. Acknowledge and return never change the flags.
- R4: Source index 7 has the highest priority and index 0 the lowest. With no service active, the request rises one clock after an event. The vector index is then the highest pending source index. The vector reads 0 whenever the request is low.
- R5: During a service, a pending trap raises the request only if its index is strictly greater than the in-service level. A trap of equal or lower index stays pending with the request low.
- R6: An acknowledge while the request is high has these effects at the next clock edge. The offered index becomes the in-service level, the block output goes high, and that source leaves the pending set. Its flag bit stays as it was.
- R7: A return pops the in-service stack at the next edge and restores the previously active level. After the last return, the block output is low and the in-service level reads 0. Any remaining pending trap is then requested again. A return with no service active has no effect.
- R8: The block output is high exactly while a service is active. The ordinary pass output is high only when the ordinary level input is non-zero and the block output is low. The event-transfer pass output is high only when its request input is high and the block output is low.
- R9: When acknowledge and return arrive in the same cycle, only the return acts. The acknowledge is ignored and the pending trap is still requested afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_evt_i | input | 8 | One bit per trap source; high marks an occurrence in that cycle |
| flag_wr_i | input | 1 | Software write strobe for the flag register |
| flag_wdata_i | input | 8 | Write data; 0 clears the bit, 1 keeps it |
| flag_o | output | 8 | Flag register read value |
| trap_req_o | output | 1 | Trap service request to the core |
| trap_vec_o | output | 3 | Vector index of the requested trap |
| ack_i | input | 1 | Core pulse on trap vector entry |
| ret_i | input | 1 | Core pulse on return from a trap handler |
| srv_level_o | output | 3 | Index of the trap currently in service, 0 when idle |
| block_o | output | 1 | High while any trap service is active |
| ord_level_i | input | 4 | Level of the pending ordinary interrupt, 0 for none |
| ord_pass_o | output | 1 | Ordinary request allowed through |
| pec_req_i | input | 1 | Peripheral-event transfer request |
| pec_pass_o | output | 1 | Event-transfer request allowed through |

## Verification
Flags, pending state and the service stack are all registered. An event, a write, an acknowledge or a return therefore shows on flag_o, trap_req_o, trap_vec_o, srv_level_o and block_o one clock after the edge that samples it. The two pass outputs follow their inputs and the block output within the same cycle. The bench drives each stimulus at a falling edge and lets exactly one rising edge pass. It compares the registered results at the next falling edge. For the pass outputs, it compares a short delay after changing the inputs, with no edge in between.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    typedef struct packed {
        logic ack;
        logic ret;
        logic req;
        logic active;
    } stk_ctl_t;

    function automatic stk_op_e pick_stk_op(stk_ctl_t c);
        if (c.ret && c.active)
            return STK_POP;
        else if (!c.ret && c.ack && c.req)
            return STK_PUSH;
        else
            return STK_HOLD;
    endfunction

endpackage

// File: rtl/trap_flags.sv
module trap_flags #(
    parameter int N  = 8,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  evt_i,
    input  logic          wr_i,
    input  logic [N-1:0]  wdata_i,
    input  logic          take_i,
    input  logic [LW-1:0] take_idx_i,
    output logic [N-1:0]  flags_o,
    output logic [N-1:0]  pend_o
);
    logic [N-1:0] flags_q, pend_q;
    logic [N-1:0] take_mask;
    logic [N-1:0] keep_mask;

    always_comb begin
        take_mask = '0;
        if (take_i)
            take_mask[take_idx_i] = 1'b1;
        keep_mask = wr_i ? wdata_i : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            pend_q  <= '0;
        end else begin
            flags_q <= (flags_q & keep_mask) | evt_i;
            pend_q  <= (pend_q & ~take_mask) | evt_i;
        end
    end

    assign flags_o = flags_q;
    assign pend_o  = pend_q;
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
    parameter int N  = 8,
    parameter int LW = 3
) (
    input  logic [N-1:0]  pend_i,
    input  logic          active_i,
    input  logic [LW-1:0] cur_lvl_i,
    output logic          req_o,
    output logic [LW-1:0] vec_o
);
    logic [LW-1:0] top;
    logic          found;
    logic          elig;

    always_comb begin
        top   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i]) begin
                top   = LW'(i);
                found = 1'b1;
            end
        end
        elig  = found && (!active_i || (top > cur_lvl_i));
        req_o = elig;
        vec_o = elig ? top : '0;
    end
endmodule

// File: rtl/trap_stack.sv
module trap_stack #(
    parameter int N  = 8,
    parameter int LW = 3,
    parameter int DW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  trap_pkg::stk_op_e op_i,
    input  logic [LW-1:0]     push_lvl_i,
    output logic              active_o,
    output logic [LW-1:0]     top_lvl_o
);
    import trap_pkg::*;

    logic [LW-1:0] stk_q [N];
    logic [DW-1:0] depth_q;
    logic [LW-1:0] top_idx;
    logic [LW-1:0] wr_idx;

    assign top_idx = LW'(depth_q - DW'(1));
    assign wr_idx  = LW'(depth_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
            for (int i = 0; i < N; i++)
                stk_q[i] <= '0;
        end else begin
            case (op_i)
                STK_PUSH: begin
                    if (depth_q < DW'(N)) begin
                        stk_q[wr_idx] <= push_lvl_i;
                        depth_q       <= depth_q + DW'(1);
                    end
                end
                STK_POP: begin
                    if (depth_q != '0)
                        depth_q <= depth_q - DW'(1);
                end
                default: ;
            endcase
        end
    end

    assign active_o  = (depth_q != '0);
    assign top_lvl_o = active_o ? stk_q[top_idx] : '0;
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
    parameter int NUM_TRAPS = 8,
    parameter int ORD_W     = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_TRAPS-1:0]         trap_evt_i,
    input  logic                         flag_wr_i,
    input  logic [NUM_TRAPS-1:0]         flag_wdata_i,
    output logic [NUM_TRAPS-1:0]         flag_o,
    output logic                         trap_req_o,
    output logic [$clog2(NUM_TRAPS)-1:0] trap_vec_o,
    input  logic                         ack_i,
    input  logic                         ret_i,
    output logic [$clog2(NUM_TRAPS)-1:0] srv_level_o,
    output logic                         block_o,
    input  logic [ORD_W-1:0]             ord_level_i,
    output logic                         ord_pass_o,
    input  logic                         pec_req_i,
    output logic                         pec_pass_o
);
    import trap_pkg::*;

    localparam int LW = $clog2(NUM_TRAPS);
    localparam int DW = $clog2(NUM_TRAPS + 1);

    logic [NUM_TRAPS-1:0] pend;
    logic                 active;
    logic [LW-1:0]        cur_lvl;
    logic                 req;
    logic [LW-1:0]        vec;
    stk_op_e              op;
    stk_ctl_t             ctl;

    always_comb begin
        ctl.ack    = ack_i;
        ctl.ret    = ret_i;
        ctl.req    = req;
        ctl.active = active;
        op         = pick_stk_op(ctl);
    end

    trap_flags #(.N(NUM_TRAPS), .LW(LW)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (trap_evt_i),
        .wr_i       (flag_wr_i),
        .wdata_i    (flag_wdata_i),
        .take_i     (op == STK_PUSH),
        .take_idx_i (vec),
        .flags_o    (flag_o),
        .pend_o     (pend)
    );

    trap_arbiter #(.N(NUM_TRAPS), .LW(LW)) u_arb (
        .pend_i    (pend),
        .active_i  (active),
        .cur_lvl_i (cur_lvl),
        .req_o     (req),
        .vec_o     (vec)
    );

    trap_stack #(.N(NUM_TRAPS), .LW(LW), .DW(DW)) u_stk (
        .clk        (clk),
        .rst        (rst),
        .op_i       (op),
        .push_lvl_i (vec),
        .active_o   (active),
        .top_lvl_o  (cur_lvl)
    );

    assign trap_req_o  = req;
    assign trap_vec_o  = vec;
    assign srv_level_o = cur_lvl;
    assign block_o     = active;
    assign ord_pass_o  = (ord_level_i != '0) && !active;
    assign pec_pass_o  = pec_req_i && !active;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
    parameter int NUM_TRAPS = 8,
    parameter int ORD_W     = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_TRAPS-1:0]         trap_evt_i,
    input logic                         flag_wr_i,
    input logic [NUM_TRAPS-1:0]         flag_o,
    input logic                         trap_req_o,
    input logic [$clog2(NUM_TRAPS)-1:0] trap_vec_o,
    input logic                         ack_i,
    input logic                         ret_i,
    input logic [$clog2(NUM_TRAPS)-1:0] srv_level_o,
    input logic                         block_o,
    input logic                         ord_pass_o,
    input logic                         pec_pass_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (flag_o == '0) && !block_o && !trap_req_o);

    assert_evt_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (trap_evt_i != '0) |=> ((flag_o & $past(trap_evt_i)) == $past(trap_evt_i)));

    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        !flag_wr_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

    assert_preempt_higher_R5: assert property (@(posedge clk) disable iff (rst)
        (block_o && trap_req_o) |-> (trap_vec_o > srv_level_o));

    assert_ack_enters_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_i && trap_req_o && !ret_i) |=> (block_o && (srv_level_o == $past(trap_vec_o))));

    assert_block_gates_R8: assert property (@(posedge clk) disable iff (rst)
        block_o |-> (!ord_pass_o && !pec_pass_o));
endmodule

bind trap_ctrl trap_ctrl_chk #(.NUM_TRAPS(NUM_TRAPS), .ORD_W(ORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .trap_evt_i  (trap_evt_i),
    .flag_wr_i   (flag_wr_i),
    .flag_o      (flag_o),
    .trap_req_o  (trap_req_o),
    .trap_vec_o  (trap_vec_o),
    .ack_i       (ack_i),
    .ret_i       (ret_i),
    .srv_level_o (srv_level_o),
    .block_o     (block_o),
    .ord_pass_o  (ord_pass_o),
    .pec_pass_o  (pec_pass_o)
);

// File: tb/trap_ctrl_bench.sv
module trap_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] trap_evt_i = '0;
    logic       flag_wr_i = 1'b0;
    logic [7:0] flag_wdata_i = '0;
    logic [7:0] flag_o;
    logic       trap_req_o;
    logic [2:0] trap_vec_o;
    logic       ack_i = 1'b0;
    logic       ret_i = 1'b0;
    logic [2:0] srv_level_o;
    logic       block_o;
    logic [3:0] ord_level_i = '0;
    logic       ord_pass_o;
    logic       pec_req_i = 1'b0;
    logic       pec_pass_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trap_ctrl u_trap_ctrl (
        .clk(clk), .rst(rst),
        .trap_evt_i(trap_evt_i), .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
        .flag_o(flag_o), .trap_req_o(trap_req_o), .trap_vec_o(trap_vec_o),
        .ack_i(ack_i), .ret_i(ret_i), .srv_level_o(srv_level_o), .block_o(block_o),
        .ord_level_i(ord_level_i), .ord_pass_o(ord_pass_o),
        .pec_req_i(pec_req_i), .pec_pass_o(pec_pass_o)
    );

    // entry: evt[34:27] wr[26] wdata[25:18] ack[17] ret[16]
    //        req[15] vec[14:12] blk[11] lvl[10:8] flags[7:0]
    localparam logic [34:0] STEPS [16] = '{
        {8'h05, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 3'd0, 8'h05},
        {8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 8'h05},
        {8'h04, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 8'h05},
        {8'h80, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 3'd7, 1'b1, 3'd2, 8'h85},
        {8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 3'd7, 8'h85},
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 3'd2, 8'h85},
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 3'd0, 8'h85},
        {8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 3'd2, 1'b0, 3'd0, 8'h85},
        {8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 8'h85},
        {8'h08, 1'b1, 8'hFB, 1'b0, 1'b0, 1'b1, 3'd3, 1'b1, 3'd2, 8'h89},
        {8'h01, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 3'd3, 1'b1, 3'd2, 8'h01},
        {8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 3'd3, 8'h01},
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 3'd2, 8'h01},
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 3'd0, 8'h01},
        {8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 3'd0, 8'h01},
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 8'h01}
    };

    task automatic chk(input string tag, input int step, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s step %0d: actual %h expected %h", tag, step, act, exp);
        end
    endtask

    task automatic idle_inputs();
        trap_evt_i = '0; flag_wr_i = 1'b0; flag_wdata_i = '0; ack_i = 1'b0; ret_i = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state on the first cycle after reset
        chk("R1 flags", -1, flag_o, 8'h00);
        chk("R1 req", -1, {7'd0, trap_req_o}, 8'h00);
        chk("R1 block", -1, {7'd0, block_o}, 8'h00);
        chk("R1 level", -1, {5'd0, srv_level_o}, 8'h00);

        for (int s = 0; s < 16; s++) begin
            trap_evt_i   = STEPS[s][34:27];
            flag_wr_i    = STEPS[s][26];
            flag_wdata_i = STEPS[s][25:18];
            ack_i        = STEPS[s][17];
            ret_i        = STEPS[s][16];
            @(negedge clk);
            chk("R2/R3 flags", s, flag_o, STEPS[s][7:0]);
            chk("R4/R5 req", s, {7'd0, trap_req_o}, {7'd0, STEPS[s][15]});
            chk("R4 vec", s, {5'd0, trap_vec_o}, {5'd0, STEPS[s][14:12]});
            chk("R6/R7 block", s, {7'd0, block_o}, {7'd0, STEPS[s][11]});
            chk("R7 level", s, {5'd0, srv_level_o}, {5'd0, STEPS[s][10:8]});
        end
        idle_inputs();

        // R8: pass-through while idle
        ord_level_i = 4'd3; pec_req_i = 1'b1;
        #1;
        chk("R8 ord pass idle", 100, {7'd0, ord_pass_o}, 8'h01);
        chk("R8 pec pass idle", 100, {7'd0, pec_pass_o}, 8'h01);

        @(negedge clk);
        trap_evt_i = 8'h10;
        @(negedge clk);
        trap_evt_i = '0;
        chk("R4 req idle", 101, {7'd0, trap_req_o}, 8'h01);
        chk("R4 vec idle", 101, {5'd0, trap_vec_o}, 8'h04);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        chk("R6 block", 102, {7'd0, block_o}, 8'h01);
        chk("R8 ord blocked", 102, {7'd0, ord_pass_o}, 8'h00);
        chk("R8 pec blocked", 102, {7'd0, pec_pass_o}, 8'h00);

        trap_evt_i = 8'h12;
        @(negedge clk);
        trap_evt_i = '0;
        chk("R5 equal/lower held", 103, {7'd0, trap_req_o}, 8'h00);
        chk("R2 flag while blocked", 103, flag_o, 8'h13);

        trap_evt_i = 8'h20;
        @(negedge clk);
        trap_evt_i = '0;
        chk("R5 higher req", 104, {7'd0, trap_req_o}, 8'h01);
        chk("R5 higher vec", 104, {5'd0, trap_vec_o}, 8'h05);

        ack_i = 1'b1; ret_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0; ret_i = 1'b0;
        chk("R9 block after ack+ret", 105, {7'd0, block_o}, 8'h00);
        chk("R9 req kept", 105, {7'd0, trap_req_o}, 8'h01);
        chk("R9 vec kept", 105, {5'd0, trap_vec_o}, 8'h05);

        flag_wr_i = 1'b1; flag_wdata_i = 8'hFF;
        @(negedge clk);
        flag_wr_i = 1'b0; flag_wdata_i = '0;
        chk("R3 write ones keeps", 106, flag_o, 8'h33);

        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 flags after reset", 107, flag_o, 8'h00);
        chk("R1 req after reset", 107, {7'd0, trap_req_o}, 8'h00);
        chk("R1 block after reset", 107, {7'd0, block_o}, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule